// File: doc/BRIEF.md
# Folded Three-Operand Adder

This block sums three sample streams, y(n) = a(n) + b(n) + c(n), with one adder that is reused over two clock cycles instead of two adders in a chain. The adder has a single register at its output. A one-bit phase counter, started by reset, splits time into even and odd slots. In an even slot the adder takes a(n) and b(n). In the following odd slot it takes the registered partial sum and a held copy of c(n). A complete result therefore leaves the block every two cycles. The final addition for one sample and the first addition for the next sample overlap in the same output register.

A sample set is presented with `in_vld` during an even slot. The first cycle after reset is released is even, and slots alternate after that. The result is two bits wider than the inputs, so it can never overflow. A parameter chooses whether the inputs are read as two's-complement or as unsigned.

Top module: `fold3_adder`

## Requirements
- R1: While reset is held, and in the cycle after a reset edge, `sum_vld` is 0 and `sum_q` is 0.
- R2: Cycles after reset release are numbered from 0. A sample set is accepted only when `in_vld` is 1 in an even-numbered cycle. The phase alternates every cycle.
- R3: For each accepted set, the result equals a+b+c exactly in DATA_W+2 bits, including when all three operands sit at the same extreme of the input range.
- R4: `sum_vld` is 1 in the cycle two cycles after the accepting cycle, and `sum_q` holds the result in that cycle.
- R5: `in_vld` raised in an odd-numbered cycle is ignored. It causes no `sum_vld` pulse and does not disturb a pending result.
- R6: Operand c is captured in the accepting cycle. Values on `in_a`, `in_b` and `in_c` in the following odd cycle do not change that result.
- R7: Sample sets offered in every even cycle are all accepted. Their results come out in order, one every two cycles.
- R8: With SIGNED_IN=0, inputs are zero-extended. For example, with DATA_W=8, 255+255+255 gives 765.
- R9: `sum_vld` is never 1 in two consecutive cycles.
- R10: A reset that arrives between acceptance and output discards the pending result. No `sum_vld` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Sample set present; taken only in even cycles |
| in_a | input | DATA_W | First operand |
| in_b | input | DATA_W | Second operand |
| in_c | input | DATA_W | Third operand |
| sum_vld | output | 1 | Result strobe, one cycle |
| sum_q | output | DATA_W+2 | Sum of the accepted set |

## Verification
A phase counter that starts on the wrong slot, or that stops alternating, shows up as lost or misplaced `sum_vld` pulses within two cycles of the first sample. A wrong select or a stale c register gives a result that is off by one operand, and this appears on the first strobe after the fault. A sign-extension error only shows when the operands are negative or at the range limits. The bench therefore includes extreme values, and it runs an unsigned instance next to the signed one.

// File: rtl/fold3_pkg.sv
package fold3_pkg;
   // slot of the two-cycle schedule
   typedef enum logic {
      PH_AB = 1'b0,   // adder sees a and b
      PH_CF = 1'b1    // adder sees feedback and held c
   } phase_t;
endpackage

// File: rtl/fold3_phase_ctl.sv
module fold3_phase_ctl
   import fold3_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  logic   in_vld,
   output phase_t phase,
   output logic   take,
   output logic   part_vld,
   output logic   out_vld
);
   assign take = in_vld && (phase == PH_AB);

   always_ff @(posedge clk) begin
      if (rst) begin
         phase    <= PH_AB;
         part_vld <= 1'b0;
         out_vld  <= 1'b0;
      end else begin
         phase    <= (phase == PH_AB) ? PH_CF : PH_AB;
         part_vld <= take;
         out_vld  <= part_vld;
      end
   end

   // R2
   phase_alt_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> phase != $past(phase));
   // R5
   odd_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_CF) |=> !part_vld);
   // R9
   vld_gap_chk: assert property (@(posedge clk) disable iff (rst)
      out_vld |=> !out_vld);
   // R4
   vld_lat_chk: assert property (@(posedge clk) disable iff (rst)
      out_vld |-> ($past(in_vld, 2) && ($past(phase, 2) == PH_AB)));
endmodule

// File: rtl/fold3_opnd_mux.sv
module fold3_opnd_mux
   import fold3_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int SUM_W     = DATA_W + 2,
   parameter bit SIGNED_IN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  phase_t            phase,
   input  logic [DATA_W-1:0] in_a,
   input  logic [DATA_W-1:0] in_b,
   input  logic [DATA_W-1:0] in_c,
   input  logic [SUM_W-1:0]  fb,
   output logic [SUM_W-1:0]  op_x,
   output logic [SUM_W-1:0]  op_y
);
   localparam int EXT_W = SUM_W - DATA_W;

   logic [SUM_W-1:0] a_ext, b_ext, c_ext, c_q;

   if (SIGNED_IN) begin : g_sext
      assign a_ext = {{EXT_W{in_a[DATA_W-1]}}, in_a};
      assign b_ext = {{EXT_W{in_b[DATA_W-1]}}, in_b};
      assign c_ext = {{EXT_W{in_c[DATA_W-1]}}, in_c};
   end else begin : g_zext
      assign a_ext = {{EXT_W{1'b0}}, in_a};
      assign b_ext = {{EXT_W{1'b0}}, in_b};
      assign c_ext = {{EXT_W{1'b0}}, in_c};
   end

   // c waits one cycle for its turn at the adder
   always_ff @(posedge clk) begin
      if (rst)                 c_q <= '0;
      else if (phase == PH_AB) c_q <= c_ext;
   end

   always_comb begin
      if (phase == PH_AB) begin
         op_x = a_ext;
         op_y = b_ext;
      end else begin
         op_x = fb;
         op_y = c_q;
      end
   end

   // R6
   c_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_CF) |-> c_q == $past(c_ext));
endmodule

// File: rtl/fold3_shared_add.sv
module fold3_shared_add #(
   parameter int SUM_W = 18
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SUM_W-1:0] op_x,
   input  logic [SUM_W-1:0] op_y,
   output logic [SUM_W-1:0] acc_q
);
   always_ff @(posedge clk) begin
      if (rst) acc_q <= '0;
      else     acc_q <= op_x + op_y;
   end
endmodule

// File: rtl/fold3_adder.sv
module fold3_adder
   import fold3_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter bit SIGNED_IN = 1'b1,
   localparam int SUM_W    = DATA_W + 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_vld,
   input  logic [DATA_W-1:0] in_a,
   input  logic [DATA_W-1:0] in_b,
   input  logic [DATA_W-1:0] in_c,
   output logic              sum_vld,
   output logic [SUM_W-1:0]  sum_q
);
   if (DATA_W < 2) begin : g_width_chk
      $error("fold3_adder: DATA_W must be at least 2");
   end

   phase_t           phase;
   logic             take, part_vld, out_vld;
   logic [SUM_W-1:0] op_x, op_y, acc_q;

   fold3_phase_ctl u_ctl (
      .clk(clk), .rst(rst), .in_vld(in_vld),
      .phase(phase), .take(take), .part_vld(part_vld), .out_vld(out_vld)
   );

   fold3_opnd_mux #(.DATA_W(DATA_W), .SUM_W(SUM_W), .SIGNED_IN(SIGNED_IN)) u_mux (
      .clk(clk), .rst(rst), .phase(phase),
      .in_a(in_a), .in_b(in_b), .in_c(in_c), .fb(acc_q),
      .op_x(op_x), .op_y(op_y)
   );

   fold3_shared_add #(.SUM_W(SUM_W)) u_add (
      .clk(clk), .rst(rst), .op_x(op_x), .op_y(op_y), .acc_q(acc_q)
   );

   assign sum_vld = out_vld;
   assign sum_q   = acc_q;

   // port-level reference for the result check
   logic [SUM_W-1:0] chk_total;
   assign chk_total = SIGNED_IN ?
      (SUM_W'($signed(in_a)) + SUM_W'($signed(in_b)) + SUM_W'($signed(in_c))) :
      (SUM_W'(in_a) + SUM_W'(in_b) + SUM_W'(in_c));

   // R3
   total_chk: assert property (@(posedge clk) disable iff (rst)
      sum_vld |-> sum_q == $past(chk_total, 2));
   // R1
   rst_clear_chk: assert property (@(posedge clk)
      $past(rst) |-> (!sum_vld && sum_q == '0));
endmodule

// File: tb/fold3_adder_tb.sv
module fold3_adder_tb;
   localparam int CLK_P = 10;
   localparam int TAB_N = 8;
   localparam logic [15:0] TAB_A [TAB_N] = '{16'd1, 16'hFFFB, 16'h7FFF, 16'h8000, 16'd100,  16'hFFFF, 16'd12345, 16'h7FFF};
   localparam logic [15:0] TAB_B [TAB_N] = '{16'd2, 16'd7,    16'h7FFF, 16'h8000, 16'hFF9C, 16'hFFFF, 16'hF6D7,  16'h8000};
   localparam logic [15:0] TAB_C [TAB_N] = '{16'd3, 16'hFFF7, 16'h7FFF, 16'h8000, 16'd0,    16'hFFFF, 16'd1000,  16'd1};
   localparam int          TAB_Y [TAB_N] = '{6, -7, 98301, -98304, 0, -3, 11000, 0};

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_vld = 1'b0;
   logic [15:0] in_a = '0, in_b = '0, in_c = '0;
   logic sum_vld;
   logic [17:0] sum_q;
   logic u_vld = 1'b0;
   logic [7:0] u_a = '0, u_b = '0, u_c = '0;
   logic u_sum_vld;
   logic [9:0] u_sum_q;
   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   fold3_adder #(.DATA_W(16), .SIGNED_IN(1'b1)) u_dut (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_a(in_a), .in_b(in_b), .in_c(in_c),
      .sum_vld(sum_vld), .sum_q(sum_q)
   );

   fold3_adder #(.DATA_W(8), .SIGNED_IN(1'b0)) u_dut_uns (
      .clk(clk), .rst(rst), .in_vld(u_vld), .in_a(u_a), .in_b(u_b), .in_c(u_c),
      .sum_vld(u_sum_vld), .sum_q(u_sum_q)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 vld in reset", sum_vld, 0);
      chk("R1 sum in reset", $signed(sum_q), 0);
      chk("R1 uns vld in reset", u_sum_vld, 0);
      rst = 1'b0;   // next edge closes even cycle 0

      // table walk: full-rate stream with odd-slot disturbance
      for (int j = 0; j <= TAB_N; j++) begin
         if (j > 0) begin
            chk("R4 vld", sum_vld, 1);
            chk("R3 R7 sum", $signed(sum_q), TAB_Y[j-1]);
         end
         if (j < TAB_N) begin
            in_a = TAB_A[j]; in_b = TAB_B[j]; in_c = TAB_C[j]; in_vld = 1'b1;
         end else in_vld = 1'b0;
         step();
         chk("R9 odd slot vld", sum_vld, 0);
         // R5 R6: junk with strobe in the odd slot
         in_a = 16'h1234; in_b = 16'h4321; in_c = 16'h7FFF; in_vld = 1'b1;
         step();
      end
      in_vld = 1'b0;
      chk("R5 no pulse from odd strobe", sum_vld, 0);

      // R2: odd-only strobe never accepted
      step();
      in_a = 16'd9; in_b = 16'd9; in_c = 16'd9; in_vld = 1'b1;   // odd slot
      step();
      in_vld = 1'b0;
      for (int k = 0; k < 3; k++) begin
         chk("R2 odd strobe ignored", sum_vld, 0);
         step();
      end
      // now odd slot; move to even
      step();
      in_a = 16'd3; in_b = 16'd4; in_c = 16'd5; in_vld = 1'b1;
      step();
      in_vld = 1'b0;
      step();
      chk("R2 even accept vld", sum_vld, 1);
      chk("R2 even accept sum", $signed(sum_q), 12);

      // R8: unsigned instance
      u_a = 8'd255; u_b = 8'd255; u_c = 8'd255; u_vld = 1'b1;
      step();
      u_vld = 1'b0; u_c = 8'd0;
      step();
      chk("R8 uns vld", u_sum_vld, 1);
      chk("R8 uns max", u_sum_q, 765);
      u_a = 8'd200; u_b = 8'd0; u_c = 8'd129; u_vld = 1'b1;
      step();
      u_vld = 1'b0;
      step();
      chk("R8 uns mixed", u_sum_q, 329);

      // R10: reset between accept and output
      in_a = 16'd1; in_b = 16'd1; in_c = 16'd1; in_vld = 1'b1;
      step();
      in_vld = 1'b0; rst = 1'b1;
      step();
      chk("R10 R1 vld after reset edge", sum_vld, 0);
      chk("R10 R1 sum after reset edge", $signed(sum_q), 0);
      rst = 1'b0;
      for (int k = 0; k < 4; k++) begin
         step();
         chk("R10 no stale pulse", sum_vld, 0);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule